// File: doc/BRIEF.md
# SDRAM Single-Access Read/Write Engine

This block turns one word request at a time into a closed-page command sequence on an SDRAM with four banks. Each bank holds 4096 rows of 256 sixteen-bit columns. A request carries a flat 22-bit word address, a 16-bit write word and a direction flag. For each request the engine opens the addressed row, issues one column command, then closes the bank again before it takes the next request. Read words come back on a separate port, framed by a one-cycle strobe, after the programmed CAS latency.

The engine is used once the memory has been brought up and its mode register has been written by other logic. Every pin toward the memory comes straight from a flop. The data bus is split into an output word, an output enable and an input word, so that the pad-level tri-state buffer can sit outside the block. The output enable is high only while a write command is on the pins.

Top module: `sdram_access_engine`

## Requirements
- R1: The request address is split as bank = addr[21:20], row = addr[19:8] and column = addr[7:0]. Activate carries the bank on `mem_ba` and the row on `mem_a[11:0]`. Read and write carry the same bank and put the column on `mem_a[7:0]`, with `mem_a[11:8]` at zero, so auto-precharge (A10) is off.
- R2: The command is encoded on {CS#, RAS#, CAS#, WE#} as follows: activate 0011, read 0101, write 0100, precharge 0010, no-op 0111. Deselect is 1111. No other code ever appears, and a cycle with no command shows no-op or deselect.
- R3: A request is taken at a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the engine is idle. The activate appears on the pins in the cycle right after the accepting edge. A request held while `req_ready` is low is not taken until `req_ready` rises.
- R4: The read or write command appears exactly T_RCD cycles (default 3) after the activate.
- R5: A single-bank precharge appears exactly T_WR cycles (default 2) after the column command. It has A10 low and the bank of the access.
- R6: `req_ready` rises T_RP−1 cycles after the precharge, so the next activate comes no sooner than T_RP cycles (default 3) after it.
- R7: `mem_dq_oe` is high exactly in the cycles where the write command is on the pins. In those cycles `mem_dq_o` equals the request's write word.
- R8: `mem_dq_i` is sampled at the CAS_LAT-th rising edge (default 3) after the edge that puts the read command on the pins. The word appears on `rd_data` with `rd_valid` high for one cycle right after that edge. A read returns the word last written to the same flat address.
- R9: `mem_dqm` is 2'b00 in every cycle that carries a read or write command.
- R10: While reset is high the pins show deselect, `mem_dq_oe` is 0, `mem_dqm` is 2'b11 and `rd_valid` is 0. After reset `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Flat word address |
| req_wdata | input | 16 | Write word |
| req_ready | output | 1 | Engine idle, request can be taken |
| rd_valid | output | 1 | One-cycle strobe for returned read word |
| rd_data | output | 16 | Returned read word |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | 2 | Bank select |
| mem_a | output | 12 | Row / column address pins |
| mem_dqm | output | 2 | Byte masks |
| mem_dq_o | output | 16 | Data toward memory |
| mem_dq_oe | output | 1 | Enable for the data pad driver |
| mem_dq_i | input | 16 | Data from memory |

## Verification
The hardest case to reach from the ports is a wrong capture edge for read data. It only shows if the bus holds the right word for exactly one cycle and different values around it. The bench models the memory at the pins. It puts the stored word on `mem_dq_i` only in the single cycle before the expected capture edge and fills every other cycle with a value that changes each cycle. A second case is a request held while the engine is busy. The bench raises `req_valid` in the middle of a sequence and checks that no activate appears before `req_ready` returns. Bank and row corners, unwritten addresses and overwrites complete the stimulus.

// File: rtl/sdram_eng_pkg.sv
package sdram_eng_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_ACT   = 4'b0011,
    CMD_PRE   = 4'b0010,
    CMD_WR    = 4'b0100,
    CMD_RD    = 4'b0101,
    CMD_NOP   = 4'b0111,
    CMD_DESEL = 4'b1111
  } sdram_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RCD,
    ST_PRE,
    ST_RP
  } seq_state_e;

endpackage

// File: rtl/sdram_addr_split.sv
module sdram_addr_split #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  localparam int AW    = BANK_W + ROW_W + COL_W
) (
  input  logic [AW-1:0]     addr,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col
);
  assign bank = addr[AW-1 -: BANK_W];
  assign row  = addr[COL_W +: ROW_W];
  assign col  = addr[COL_W-1:0];
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_eng_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 12,
  parameter int COL_W   = 8,
  parameter int DATA_W  = 16,
  parameter int T_RCD   = 3,
  parameter int T_WR    = 2,
  parameter int T_RP    = 3,
  localparam int DQM_W  = DATA_W / 8,
  localparam int MAX_T  = (T_RCD > T_WR) ? ((T_RCD > T_RP) ? T_RCD : T_RP)
                                         : ((T_WR > T_RP) ? T_WR : T_RP),
  localparam int CNT_W  = $clog2(MAX_T + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              rd_busy,
  output logic              req_ready,
  output logic              rd_fire,
  output sdram_cmd_e        cmd_q,
  output logic [BANK_W-1:0] ba_q,
  output logic [ROW_W-1:0]  a_q,
  output logic [DQM_W-1:0]  dqm_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              oe_q
);
  // T_RP must be at least 2: the recovery counter is loaded with T_RP-1.
  seq_state_e        state, state_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  sdram_cmd_e        cmd_n;
  logic [ROW_W-1:0]  a_n;
  logic [BANK_W-1:0] ba_n;
  logic              oe_n;
  logic              take;
  logic              wr_q;
  logic [COL_W-1:0]  col_q;
  logic              last;

  assign req_ready = (state == ST_IDLE);
  assign last      = (cnt == CNT_W'(1));

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    cmd_n   = CMD_NOP;
    a_n     = a_q;
    ba_n    = ba_q;
    oe_n    = 1'b0;
    take    = 1'b0;
    rd_fire = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (req_valid) begin
          state_n = ST_RCD;
          cnt_n   = CNT_W'(T_RCD);
          cmd_n   = CMD_ACT;
          ba_n    = req_bank;
          a_n     = req_row;
          take    = 1'b1;
        end
      end
      ST_RCD: begin
        if (last) begin
          state_n = ST_PRE;
          cnt_n   = CNT_W'(T_WR);
          cmd_n   = wr_q ? CMD_WR : CMD_RD;
          a_n     = ROW_W'(col_q);
          oe_n    = wr_q;
          rd_fire = !wr_q;
        end else begin
          cnt_n = cnt - CNT_W'(1);
        end
      end
      ST_PRE: begin
        if (last) begin
          state_n = ST_RP;
          cnt_n   = CNT_W'(T_RP - 1);
          cmd_n   = CMD_PRE;
          a_n     = '0;
        end else begin
          cnt_n = cnt - CNT_W'(1);
        end
      end
      ST_RP: begin
        if (last) state_n = ST_IDLE;
        else      cnt_n   = cnt - CNT_W'(1);
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      cmd_q   <= CMD_DESEL;
      ba_q    <= '0;
      a_q     <= '0;
      oe_q    <= 1'b0;
      dqm_q   <= '1;
      wr_q    <= 1'b0;
      col_q   <= '0;
      wdata_q <= '0;
    end else begin
      state <= state_n;
      cnt   <= cnt_n;
      cmd_q <= cmd_n;
      ba_q  <= ba_n;
      a_q   <= a_n;
      oe_q  <= oe_n;
      dqm_q <= ((state_n != ST_IDLE) || rd_busy) ? '0 : '1;
      if (take) begin
        wr_q    <= req_write;
        col_q   <= req_col;
        wdata_q <= req_wdata;
      end
    end
  end
endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
  parameter int DATA_W  = 16,
  parameter int CAS_LAT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_fire,
  input  logic [DATA_W-1:0] dq_i,
  output logic              rd_busy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  // bit k set: a read command has been on the pins for k+1 cycles
  logic [CAS_LAT-1:0] pipe;

  generate
    if (CAS_LAT == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= rd_fire;
      end
    end else begin : g_shift
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[CAS_LAT-2:0], rd_fire};
      end
    end
  endgenerate

  assign rd_busy = |pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= pipe[CAS_LAT-1];
      if (pipe[CAS_LAT-1]) rd_data <= dq_i;
    end
  end
endmodule

// File: rtl/sdram_access_engine.sv
module sdram_access_engine
  import sdram_eng_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 12,
  parameter int COL_W   = 8,
  parameter int DATA_W  = 16,
  parameter int T_RCD   = 3,
  parameter int T_WR    = 2,
  parameter int T_RP    = 3,
  parameter int CAS_LAT = 3,
  localparam int AW     = BANK_W + ROW_W + COL_W,
  localparam int DQM_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_cs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic [BANK_W-1:0] mem_ba,
  output logic [ROW_W-1:0]  mem_a,
  output logic [DQM_W-1:0]  mem_dqm,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  logic [BANK_W-1:0] s_bank;
  logic [ROW_W-1:0]  s_row;
  logic [COL_W-1:0]  s_col;
  logic              rd_fire;
  logic              rd_busy;
  sdram_cmd_e        cmd_q;

  sdram_addr_split #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_split (
    .addr (req_addr),
    .bank (s_bank),
    .row  (s_row),
    .col  (s_col)
  );

  sdram_cmd_seq #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .T_RCD(T_RCD), .T_WR(T_WR), .T_RP(T_RP)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_bank  (s_bank),
    .req_row   (s_row),
    .req_col   (s_col),
    .req_wdata (req_wdata),
    .rd_busy   (rd_busy),
    .req_ready (req_ready),
    .rd_fire   (rd_fire),
    .cmd_q     (cmd_q),
    .ba_q      (mem_ba),
    .a_q       (mem_a),
    .dqm_q     (mem_dqm),
    .wdata_q   (mem_dq_o),
    .oe_q      (mem_dq_oe)
  );

  sdram_rd_capture #(.DATA_W(DATA_W), .CAS_LAT(CAS_LAT)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .rd_fire  (rd_fire),
    .dq_i     (mem_dq_i),
    .rd_busy  (rd_busy),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  assign mem_cs_n  = cmd_q[3];
  assign mem_ras_n = cmd_q[2];
  assign mem_cas_n = cmd_q[1];
  assign mem_we_n  = cmd_q[0];
endmodule

// File: rtl/sdram_access_engine_chk.sv
module sdram_access_engine_chk #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int DQM_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rd_valid,
  input logic              mem_cs_n,
  input logic              mem_ras_n,
  input logic              mem_cas_n,
  input logic              mem_we_n,
  input logic [ROW_W-1:0]  mem_a,
  input logic [DQM_W-1:0]  mem_dqm,
  input logic              mem_dq_oe
);
  logic [3:0] pins;
  logic is_act, is_rd, is_wr, is_pre;
  assign pins   = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
  assign is_act = (pins == 4'b0011);
  assign is_rd  = (pins == 4'b0101);
  assign is_wr  = (pins == 4'b0100);
  assign is_pre = (pins == 4'b0010);

  p_legal_code_r2: assert property (@(posedge clk) disable iff (rst)
    is_act || is_rd || is_wr || is_pre || pins == 4'b0111 || pins == 4'b1111);

  p_act_after_take_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> is_act);

  p_quiet_when_ready_r3: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !(is_act || is_rd || is_wr));

  p_col_no_autopre_r1: assert property (@(posedge clk) disable iff (rst)
    (is_rd || is_wr) |-> (mem_a[10] == 1'b0));

  p_pre_one_bank_r5: assert property (@(posedge clk) disable iff (rst)
    is_pre |-> (mem_a[10] == 1'b0));

  p_oe_with_write_r7: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe == is_wr);

  p_mask_open_r9: assert property (@(posedge clk) disable iff (rst)
    (is_rd || is_wr) |-> (mem_dqm == '0));

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
endmodule

bind sdram_access_engine sdram_access_engine_chk #(
  .BANK_W(BANK_W), .ROW_W(ROW_W), .DQM_W(DQM_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rd_valid  (rd_valid),
  .mem_cs_n  (mem_cs_n),
  .mem_ras_n (mem_ras_n),
  .mem_cas_n (mem_cas_n),
  .mem_we_n  (mem_we_n),
  .mem_a     (mem_a),
  .mem_dqm   (mem_dqm),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sdram_access_engine_tb.sv
module sdram_access_engine_tb;
  localparam int T_RCD = 3;
  localparam int T_WR  = 2;
  localparam int T_RP  = 3;
  localparam int CL    = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rd_valid;
  logic [15:0] rd_data;
  logic        mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_dq_oe;
  logic [1:0]  mem_ba, mem_dqm;
  logic [11:0] mem_a;
  logic [15:0] mem_dq_o;
  logic [15:0] mem_dq_i = '0;

  always #5 clk = ~clk;

  sdram_access_engine #(.T_RCD(T_RCD), .T_WR(T_WR), .T_RP(T_RP), .CAS_LAT(CL)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_cs_n(mem_cs_n),
    .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
    .mem_ba(mem_ba), .mem_a(mem_a), .mem_dqm(mem_dqm), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [15:0] dflt(int k);
    return 16'((k * 37) ^ (k >> 5) ^ 16'hA5A5);
  endfunction

  // reference and pin-side memory model
  logic [15:0] ref_mem [int];
  logic [15:0] dev_mem [int];
  logic [11:0] open_row [4];
  logic [15:0] exp_q [$];
  int          vdue_q [$];
  int          ddue_q [$];
  logic [15:0] ddat_q [$];
  int  cyc = 0, t_acc = 0, t_act = 0, t_rw = 0, t_pre = -100, acc_cnt = 0;
  bit  busy = 0, open = 0, pre_done = 0, cur_w = 0;
  logic [21:0] cur_a = '0;
  logic [15:0] cur_d = '0;

  always @(negedge clk) begin
    logic [3:0] c;
    int k;
    #2;
    cyc++;
    if (!rst && !done) begin
      c = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
      if (busy && pre_done && cyc == t_pre + T_RP - 1) busy = 0;
      chk(req_ready == !busy, "R6", "req_ready", req_ready, !busy);
      case (c)
        4'b0011: begin
          chk(busy && cyc == t_acc + 1, "R3", "activate cycle", cyc, t_acc + 1);
          chk(cyc - t_pre >= T_RP, "R6", "precharge to activate", cyc - t_pre, T_RP);
          chk(mem_ba == cur_a[21:20], "R1", "act bank", mem_ba, cur_a[21:20]);
          chk(mem_a == cur_a[19:8], "R1", "act row", mem_a, cur_a[19:8]);
          open_row[mem_ba] = mem_a;
          open = 1; t_act = cyc;
        end
        4'b0101, 4'b0100: begin
          chk(open && cyc == t_act + T_RCD, "R4", "column cmd cycle", cyc, t_act + T_RCD);
          chk(c[0] == !cur_w, "R2", "column cmd code", c, cur_w ? 4'b0100 : 4'b0101);
          chk(mem_ba == cur_a[21:20], "R1", "col bank", mem_ba, cur_a[21:20]);
          chk(mem_a == {4'b0, cur_a[7:0]}, "R1", "col addr", mem_a, {4'b0, cur_a[7:0]});
          chk(mem_dqm == 2'b00, "R9", "dqm on access", mem_dqm, 0);
          k = int'({mem_ba, open_row[mem_ba], mem_a[7:0]});
          if (c[0] == 1'b0) begin
            chk(mem_dq_o == cur_d, "R7", "write word", mem_dq_o, cur_d);
            dev_mem[k] = mem_dq_o;
          end else begin
            ddue_q.push_back(cyc + CL - 1);
            ddat_q.push_back(dev_mem.exists(k) ? dev_mem[k] : dflt(k));
            vdue_q.push_back(cyc + CL);
          end
          t_rw = cyc;
        end
        4'b0010: begin
          chk(open && cyc == t_rw + T_WR, "R5", "precharge cycle", cyc, t_rw + T_WR);
          chk(mem_ba == cur_a[21:20] && mem_a[10] == 1'b0, "R5", "precharge bank/A10",
              {mem_ba, mem_a[10]}, {cur_a[21:20], 1'b0});
          open = 0; pre_done = 1; t_pre = cyc;
        end
        4'b0111, 4'b1111: ;
        default: chk(0, "R2", "illegal command", c, 4'b0111);
      endcase
      chk(mem_dq_oe == (c == 4'b0100), "R7", "output enable", mem_dq_oe, c == 4'b0100);
      if (vdue_q.size() > 0 && vdue_q[0] == cyc) begin
        logic [15:0] e;
        void'(vdue_q.pop_front());
        e = exp_q.pop_front();
        chk(rd_valid == 1'b1, "R8", "rd_valid", rd_valid, 1);
        chk(rd_data == e, "R8", "rd_data", rd_data, e);
      end else begin
        chk(rd_valid == 1'b0, "R8", "rd_valid idle", rd_valid, 0);
      end
      if (ddue_q.size() > 0 && ddue_q[0] == cyc) begin
        void'(ddue_q.pop_front());
        mem_dq_i = ddat_q.pop_front();
      end else begin
        mem_dq_i = 16'(cyc * 16'h3B1 + 16'h7);
      end
      if (req_valid && req_ready) begin
        busy = 1; pre_done = 0; t_acc = cyc;
        cur_w = req_write; cur_a = req_addr; cur_d = req_wdata;
        acc_cnt++;
        if (req_write) ref_mem[int'(req_addr)] = req_wdata;
        else exp_q.push_back(ref_mem.exists(int'(req_addr)) ?
                             ref_mem[int'(req_addr)] : dflt(int'(req_addr)));
      end
    end
  end

  task automatic do_req(bit w, logic [21:0] a, logic [15:0] d, bit early);
    int c0;
    @(negedge clk);
    if (!early) while (!req_ready) @(negedge clk);
    c0 = acc_cnt;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (acc_cnt == c0) @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d; req_write = ~w;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); #3;
    // R10 reset state
    chk({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} == 4'b1111, "R10", "deselect",
        {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}, 4'hF);
    chk(mem_dq_oe == 1'b0, "R10", "oe", mem_dq_oe, 0);
    chk(mem_dqm == 2'b11, "R10", "dqm", mem_dqm, 3);
    chk(rd_valid == 1'b0, "R10", "rd_valid", rd_valid, 0);
    rst = 1'b0;
    @(negedge clk); #3;
    chk(req_ready == 1'b1, "R10", "ready after reset", req_ready, 1);
    // R1 corner addresses, write then read back
    do_req(1, 22'h000000, 16'h1234, 0);
    do_req(0, 22'h000000, 16'h0, 0);
    do_req(1, 22'h3FFFFF, 16'hBEEF, 0);
    do_req(1, 22'h0FFF00, 16'h0F0F, 0);
    do_req(1, 22'h1000FF, 16'hCAFE, 0);
    do_req(1, 22'h200000, 16'h5555, 0);
    do_req(0, 22'h3FFFFF, 16'h0, 0);
    do_req(0, 22'h1000FF, 16'h0, 0);
    do_req(0, 22'h0FFF00, 16'h0, 0);
    do_req(0, 22'h200000, 16'h0, 0);
    // R8 unwritten location
    do_req(0, 22'h2ABCDE, 16'h0, 0);
    // R3 requests raised while busy
    do_req(1, 22'h12345A, 16'hA1A1, 0);
    do_req(1, 22'h32345A, 16'hB2B2, 1);
    do_req(0, 22'h12345A, 16'h0, 1);
    do_req(0, 22'h32345A, 16'h0, 1);
    // overwrite same word
    do_req(1, 22'h0ABC01, 16'h1111, 0);
    do_req(1, 22'h0ABC01, 16'h2222, 1);
    do_req(0, 22'h0ABC01, 16'h0, 0);
    // scattered pattern, reads in reverse order
    for (int i = 0; i < 16; i++)
      do_req(1, 22'((i * 22'h2C9E5 + 22'h13) & 22'h3FFFFF), 16'(i * 16'h1F3 + 1), i[0]);
    for (int i = 15; i >= 0; i--)
      do_req(0, 22'((i * 22'h2C9E5 + 22'h13) & 22'h3FFFFF), 16'h0, i[1]);
    repeat (CL + 12) @(negedge clk);
    #3;
    chk(vdue_q.size() == 0, "R8", "reads outstanding", vdue_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL R3 watchdog: actual %0d expected %0d", 100000, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule